// File: doc/BRIEF.md
# Event-Tagged Bin Buffer with Single-Cycle Clear

This block is a bin-organised storage buffer for event-by-event data processing. A producer writes a payload into a numbered bin. A consumer later reads a bin back by number and receives the payload with a valid flag. Each stored word also carries the event number that was current when the write happened. A read counts as valid only when that stored number equals the event number now in force. Because of this, moving to the next event needs only one increment of the event counter. The old contents are never erased location by location.

The event counter has a finite width, so it wraps around. To stop an ancient word from looking current again after a wrap, every refresh also scrubs one bin through the second memory port. The scrub stores an empty payload and the event number being retired. A rotating pointer picks the bin, so every bin is rewritten within one lap of the pointer, and that lap is shorter than one lap of the event counter. A per-bin written-since-reset bit covers power-up and mid-run resets, so no bin ever reads as valid before it has been written.

Top module: `event_bin_buffer`

## Requirements
- R1: A refresh pulse increments `evid_o` by exactly one, visible in the cycle after the pulse. The 9-bit count wraps from 511 to 0. Without a refresh, `evid_o` holds its value.
- R2: After reset `evid_o` equals 1, and every bin reads as invalid with zero data.
- R3: A write to a bin, followed in the same event by a read of that bin, returns the written payload with `rd_valid_o` high.
- R4: `rd_valid_o` and `rd_data_o` reflect a read request exactly one clock after `rd_en_i`. A cycle without a request gives `rd_valid_o` low in the following cycle.
- R5: After a refresh, every bin written in earlier events reads as invalid.
- R6: A read and a write to the same bin in the same cycle return the bin's content from before that write.
- R7: A read requested in the same cycle as a refresh always reports an empty bin.
- R8: A write issued in the same cycle as a refresh is tagged with the new event number and reads back valid afterwards.
- R9: A bin never written since reset reads as invalid, whatever the event number.
- R10: Each refresh scrubs one bin, chosen by a pointer that starts at bin 0 after reset and advances by one per refresh. A bin written in event E therefore reads as invalid after 512 refreshes, even though `evid_o` is back at E.
- R11: When a write targets the bin the scrub pointer selects in a refresh cycle, the write is kept and the scrub of that bin is skipped.
- R12: Whenever `rd_valid_o` is low, `rd_data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_i | input | 1 | Close the current event and start the next |
| wr_en_i | input | 1 | Write strobe |
| wr_bin_i | input | 8 | Bin number for the write |
| wr_data_i | input | 16 | Payload for the write |
| rd_en_i | input | 1 | Read request strobe |
| rd_bin_i | input | 8 | Bin number for the read |
| rd_valid_o | output | 1 | Bin holds data of the current event (one cycle after the request) |
| rd_data_o | output | 16 | Payload of the bin, zero when not valid |
| evid_o | output | 9 | Current event number |

## Verification
The bench targets the wrap-around alias. It writes a bin, issues 512 refreshes and reads the bin again. A design without the rotating scrub, or with a scrub that stores the new event number, would report the stale payload as valid. It also covers same-cycle collisions: a read beside a write to the same bin, a read beside a refresh, and a write into the bin the scrub is aimed at. A design with the wrong read ordering returns the new value, and a design where the scrub wins wipes the fresh write. Reads of never-written bins after reset catch a design that trusts whatever tags the memory happens to hold.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

  // What the shared second memory port does in a given cycle.
  typedef enum logic [1:0] {
    PB_IDLE  = 2'd0,
    PB_READ  = 2'd1,
    PB_SCRUB = 2'd2
  } portb_op_e;

endpackage

// File: rtl/rlb_epoch_ctrl.sv
module rlb_epoch_ctrl #(
  parameter int EVID_W = 9,
  parameter int BIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh_i,
  input  logic              wr_en_i,
  input  logic [BIN_W-1:0]  wr_bin_i,
  output logic [EVID_W-1:0] evid_o,
  output logic [EVID_W-1:0] wr_tag_o,
  output logic [EVID_W-1:0] scrub_tag_o,
  output logic              scrub_en_o,
  output logic [BIN_W-1:0]  scrub_bin_o
);

  localparam logic [EVID_W-1:0] EVID_RESET = EVID_W'(1);

  logic [EVID_W-1:0] evid_q;
  logic [EVID_W-1:0] evid_inc;
  logic [BIN_W-1:0]  scrub_ptr_q;
  logic              scrub_clash;

  assign evid_inc = evid_q + EVID_W'(1);

  // The counter increment is the whole clear operation.
  always_ff @(posedge clk) begin
    if (rst) begin
      evid_q      <= EVID_RESET;
      scrub_ptr_q <= '0;
    end else if (refresh_i) begin
      evid_q      <= evid_inc;
      scrub_ptr_q <= scrub_ptr_q + BIN_W'(1);
    end
  end

  // A write in the refresh cycle already belongs to the new event.
  assign wr_tag_o    = refresh_i ? evid_inc : evid_q;
  // The scrub stores the retiring number, which the new number cannot equal.
  assign scrub_tag_o = evid_q;
  assign scrub_clash = wr_en_i && (wr_bin_i == scrub_ptr_q);
  assign scrub_en_o  = refresh_i && !scrub_clash;
  assign scrub_bin_o = scrub_ptr_q;
  assign evid_o      = evid_q;

endmodule

// File: rtl/rlb_tagged_ram.sv
module rlb_tagged_ram #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 25
) (
  input  logic              clk,
  // port A: write only
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  // port B: read (read-first) or write
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_addr] <= a_wdata;
    end
    if (b_en) begin
      if (b_we) begin
        mem[b_addr] <= b_wdata;
      end
      b_rdata <= mem[b_addr];
    end
  end

endmodule

// File: rtl/rlb_live_map.sv
module rlb_live_map #(
  parameter int BIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [BIN_W-1:0] set_idx,
  input  logic [BIN_W-1:0] rd_idx,
  output logic             rd_bit
);

  localparam int BINS = 1 << BIN_W;

  logic [BINS-1:0] live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      rd_bit <= 1'b0;
    end else begin
      rd_bit <= live_q[rd_idx];
      if (set_en) begin
        live_q[set_idx] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/event_bin_buffer.sv
module event_bin_buffer #(
  parameter int BIN_W  = 8,
  parameter int DATA_W = 16,
  parameter int EVID_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh_i,
  input  logic              wr_en_i,
  input  logic [BIN_W-1:0]  wr_bin_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [BIN_W-1:0]  rd_bin_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [EVID_W-1:0] evid_o
);
  import rlb_pkg::*;

  localparam int WORD_W = EVID_W + DATA_W;

  logic [EVID_W-1:0] wr_tag;
  logic [EVID_W-1:0] scrub_tag;
  logic              scrub_en;
  logic [BIN_W-1:0]  scrub_bin;
  portb_op_e         pb_op;
  logic [BIN_W-1:0]  pb_addr;
  logic [WORD_W-1:0] pb_rdata;
  logic              rd_req_q;
  logic              live_bit;
  logic [EVID_W-1:0] stored_tag;
  logic              hit;

  rlb_epoch_ctrl #(.EVID_W(EVID_W), .BIN_W(BIN_W)) u_epoch (
    .clk         (clk),
    .rst         (rst),
    .refresh_i   (refresh_i),
    .wr_en_i     (wr_en_i),
    .wr_bin_i    (wr_bin_i),
    .evid_o      (evid_o),
    .wr_tag_o    (wr_tag),
    .scrub_tag_o (scrub_tag),
    .scrub_en_o  (scrub_en),
    .scrub_bin_o (scrub_bin)
  );

  // Port B arbitration: a refresh cycle owns the port for the scrub. A read
  // in that cycle is answered as empty without touching the memory.
  always_comb begin
    if (scrub_en) begin
      pb_op = PB_SCRUB;
    end else if (rd_en_i && !refresh_i) begin
      pb_op = PB_READ;
    end else begin
      pb_op = PB_IDLE;
    end
  end

  assign pb_addr = (pb_op == PB_SCRUB) ? scrub_bin : rd_bin_i;

  rlb_tagged_ram #(.ADDR_W(BIN_W), .WORD_W(WORD_W)) u_ram (
    .clk     (clk),
    .a_we    (wr_en_i),
    .a_addr  (wr_bin_i),
    .a_wdata ({wr_tag, wr_data_i}),
    .b_en    (pb_op != PB_IDLE),
    .b_we    (pb_op == PB_SCRUB),
    .b_addr  (pb_addr),
    .b_wdata ({scrub_tag, {DATA_W{1'b0}}}),
    .b_rdata (pb_rdata)
  );

  rlb_live_map #(.BIN_W(BIN_W)) u_live (
    .clk     (clk),
    .rst     (rst),
    .set_en  (wr_en_i),
    .set_idx (wr_bin_i),
    .rd_idx  (rd_bin_i),
    .rd_bit  (live_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_q <= 1'b0;
    end else begin
      rd_req_q <= (pb_op == PB_READ);
    end
  end

  // A request cycle never carries a refresh, so the event number seen here
  // is still the one that was in force when the read was requested.
  assign stored_tag = pb_rdata[WORD_W-1:DATA_W];
  assign hit        = rd_req_q && live_bit && (stored_tag == evid_o);
  assign rd_valid_o = hit;
  assign rd_data_o  = hit ? pb_rdata[DATA_W-1:0] : '0;

endmodule

// File: rtl/rlb_checker.sv
module rlb_checker #(
  parameter int DATA_W = 16,
  parameter int EVID_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              refresh_i,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [EVID_W-1:0] evid_o
);

  AST_EVID_STEP: assert property (@(posedge clk) disable iff (rst)
    refresh_i |=> evid_o == EVID_W'($past(evid_o) + EVID_W'(1))); // R1

  AST_EVID_HOLD: assert property (@(posedge clk) disable iff (rst)
    !refresh_i |=> $stable(evid_o)); // R1

  AST_EVID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> evid_o == EVID_W'(1)); // R2

  AST_NO_REQ_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o); // R4

  AST_REFRESH_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && refresh_i) |=> !rd_valid_o); // R7

  AST_EMPTY_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> rd_data_o == '0); // R12

endmodule

bind event_bin_buffer rlb_checker #(.DATA_W(DATA_W), .EVID_W(EVID_W)) u_rlb_checker (
  .clk        (clk),
  .rst        (rst),
  .refresh_i  (refresh_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .evid_o     (evid_o)
);

// File: tb/tb_event_bin_buffer.sv
module tb_event_bin_buffer;

  localparam int BIN_W  = 8;
  localparam int DATA_W = 16;
  localparam int EVID_W = 9;
  localparam int BINS   = 1 << BIN_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              refresh_i = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [BIN_W-1:0]  wr_bin_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              rd_en_i = 1'b0;
  logic [BIN_W-1:0]  rd_bin_i = '0;
  logic              rd_valid_o;
  logic [DATA_W-1:0] rd_data_o;
  logic [EVID_W-1:0] evid_o;

  event_bin_buffer #(.BIN_W(BIN_W), .DATA_W(DATA_W), .EVID_W(EVID_W)) dut (
    .clk(clk), .rst(rst), .refresh_i(refresh_i), .wr_en_i(wr_en_i),
    .wr_bin_i(wr_bin_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_bin_i(rd_bin_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .evid_o(evid_o)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // reference model state
  logic [EVID_W-1:0] m_evid;
  logic [BIN_W-1:0]  m_ptr;
  logic [EVID_W-1:0] m_tag  [BINS];
  logic [DATA_W-1:0] m_data [BINS];
  bit                m_live [BINS];

  // scoreboard queues
  bit                q_v [$];
  logic [DATA_W-1:0] q_d [$];
  string             q_t [$];

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_evid = EVID_W'(1);
    m_ptr  = '0;
    for (int i = 0; i < BINS; i++) begin
      m_live[i] = 1'b0;
      m_tag[i]  = '0;
      m_data[i] = '0;
    end
  endtask

  // One cycle of stimulus: the expectation comes from the model before the edge.
  task automatic step(input bit rf, input bit we, input int wb, input int wd,
                      input bit re, input int rb, input string tag);
    logic [EVID_W-1:0] nev;
    @(negedge clk);
    refresh_i = rf; wr_en_i = we; wr_bin_i = BIN_W'(wb); wr_data_i = DATA_W'(wd);
    rd_en_i = re; rd_bin_i = BIN_W'(rb);
    nev = rf ? m_evid + EVID_W'(1) : m_evid;
    if (re) begin
      if (!rf && m_live[rb] && m_tag[rb] == nev) begin
        q_v.push_back(1'b1); q_d.push_back(m_data[rb]);
      end else begin
        q_v.push_back(1'b0); q_d.push_back('0);
      end
      q_t.push_back(tag);
    end
    if (rf) begin
      if (!(we && wb == int'(m_ptr))) begin
        m_tag[m_ptr]  = m_evid;
        m_data[m_ptr] = '0;
      end
      m_ptr  = m_ptr + BIN_W'(1);
      m_evid = nev;
    end
    if (we) begin
      m_tag[wb] = nev; m_data[wb] = DATA_W'(wd); m_live[wb] = 1'b1;
    end
    @(posedge clk);
    #1;
    refresh_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic check_evid(input string req);
    @(negedge clk);
    check(evid_o == m_evid, req, $sformatf("evid %0d", evid_o), $sformatf("evid %0d", m_evid));
  endtask

  // monitor: compare each read result one clock after its request
  initial begin
    bit fire;
    forever begin
      @(posedge clk);
      fire = rd_en_i;
      @(negedge clk);
      if (fire) begin
        if (q_v.size() == 0) begin
          check(1'b0, "R4", "result without request", "empty queue");
        end else begin
          bit ev; logic [DATA_W-1:0] ed; string et;
          ev = q_v.pop_front(); ed = q_d.pop_front(); et = q_t.pop_front();
          check(rd_valid_o == ev && rd_data_o == ed, et,
                $sformatf("v=%0b d=%h", rd_valid_o, rd_data_o),
                $sformatf("v=%0b d=%h", ev, ed));
        end
      end else begin
        check(rd_valid_o == 1'b0 && rd_data_o == '0, "R4 idle",
              $sformatf("v=%0b d=%h", rd_valid_o, rd_data_o), "v=0 d=0");
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", "finish");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_evid("R2 evid after reset");
    // R2 / R9: nothing written yet
    step(0, 0, 0, 0, 1, 0,   "R2 bin 0 empty after reset");
    step(0, 0, 0, 0, 1, 5,   "R9 bin 5 never written");
    step(0, 0, 0, 0, 1, 255, "R9 bin 255 never written");
    // R3 / R4: write then read
    step(0, 1, 3,   'hA1A1, 0, 0, "");
    step(0, 1, 7,   'hB2B2, 1, 3, "R3 read bin 3 one cycle after write");
    step(0, 1, 255, 'hC3C3, 1, 7, "R4 read bin 7 back to back");
    step(0, 0, 0, 0, 1, 255, "R3 read top bin");
    // R6: read-first on collision
    step(0, 1, 3, 'h5555, 1, 3, "R6 same-cycle read sees old value");
    step(0, 0, 0, 0, 1, 3, "R3 new value after collision");
    step(0, 1, 9, 'h0909, 1, 9, "R6 same-cycle read of unwritten bin");
    // R1 / R5 / R12
    step(1, 0, 0, 0, 0, 0, "");
    check_evid("R1 evid after first refresh");
    step(0, 0, 0, 0, 1, 3,   "R5 bin 3 cleared by refresh");
    step(0, 0, 0, 0, 1, 255, "R5 R12 bin 255 cleared, data zero");
    // R7: read beside refresh
    step(0, 1, 20, 'h2020, 0, 0, "");
    step(1, 0, 0, 0, 1, 20, "R7 read in refresh cycle empty");
    // R8 / R11: write to the bin the scrub points at, in a refresh cycle
    step(1, 1, int'(m_ptr), 'h7E7E, 0, 0, "");
    step(0, 0, 0, 0, 1, 2, "R11 R8 write kept over scrub of bin 2");
    step(1, 1, 40, 'h4040, 0, 0, "");
    step(0, 0, 0, 0, 1, 40, "R8 write in refresh cycle is new event");
    check_evid("R1 evid counting");
    // R10: wrap-around alias
    step(0, 1, 200, 'hDEAD, 0, 0, "");
    step(0, 0, 0, 0, 1, 200, "R10 bin 200 valid before wrap");
    for (int k = 0; k < 512; k++) begin
      step(1, 0, 0, 0, 0, 0, "");
      if (m_evid == '0) check_evid("R1 wrap 511 to 0");
    end
    check_evid("R10 evid back at start value");
    step(0, 0, 0, 0, 1, 200, "R10 stale bin invalid after wrap");
    // mixed traffic
    for (int k = 0; k < 2000; k++) begin
      int b1, b2;
      b1 = ($urandom % 4 == 0) ? 248 + ($urandom % 8) : ($urandom % 8);
      b2 = ($urandom % 4 == 0) ? 248 + ($urandom % 8) : ($urandom % 8);
      step(($urandom % 12) == 0, ($urandom % 2) == 0, b1, int'($urandom % 65536),
           ($urandom % 3) != 0, b2, "R3 R5 R6 mixed traffic");
    end
    check_evid("R1 evid after mixed traffic");
    repeat (3) @(negedge clk);
    check(q_v.size() == 0, "R4 all reads answered", $sformatf("%0d left", q_v.size()), "0 left");
    summary();
  end

endmodule